// File: doc/BRIEF.md
# Expanded-Memory Page Mapper

This block maps 16 KB slices of the real-mode CPU address space onto arbitrary 16 KB frames of a larger physical DRAM. Thirty-two page registers, each a low byte and a high byte, choose the frame for each slice. The low byte and the two lowest bits of the high byte form a 10-bit frame number. Bit 7 of the high byte enables the page. Software reaches the registers through a three-port I/O window. A pointer register picks the page register being accessed. When its bit 7 is set, the pointer steps forward after every high-byte write, so a run of page registers can be loaded in sequence.

The thirty-two windows occupy two regions. Windows 0 to 23 tile 0x40000 to 0x9FFFF, and windows 24 to 31 tile 0xD0000 to 0xEFFFF. For every CPU address, the block gives a physical address, a hit flag and an out-of-range flag. The memory controller uses the out-of-range flag to return 0xFF on reads and to drop writes.

I/O decoding is held in a small registered state machine. A change on the control inputs takes effect on the cycle after the clock edge that samples it. The states are:
- `WIN_IDLE`: nothing decoded.
- `WIN_BASE_A`: the window sits at 0x208.
- `WIN_BASE_B`: the window sits at 0x218.

The transitions are:
- enable-to-A and enable-to-B, out of idle.
- swap A-to-B and swap B-to-A, when the select input changes.
- disable-to-idle, from either base state.
- hold, in every state.

Top module: `ems_page_mapper`

## Requirements
- R1: The I/O window is decoded only while `ctl_io_en` is 1. Its base is 0x218 when `ctl_io_sel` is 1 and 0x208 when `ctl_io_sel` is 0. A control change is sampled on one clock edge and governs accesses from the following cycle onward.
- R2: base+0 reads and writes the selected page low byte, and base+1 the selected page high byte. base+2 reads and writes the 8-bit pointer. base+3 and above are not decoded.
- R3: Pointer bits [4:0] select the page register for base+0 and base+1. The pointer changes only on a write to base+2 or by R4.
- R4: When pointer bit 7 is 1, every write to base+1 adds one to pointer bits [4:0], wrapping 31 to 0, and leaves bits [7:5] unchanged.
- R5: After reset, every page low byte is 0xFF, every page high byte is 0x03, the pointer is 0x00 and the decode state is idle.
- R6: A read of an undecoded port returns 0xFF. A write to an undecoded port changes no register.
- R7: Window i covers the 16 KB block at (i+16)*16 KB for i below 24, and at (i+28)*16 KB for i from 24 to 31. No other CPU address falls in any window.
- R8: A window translates only when `ctl_map_en` is 1 and bit 7 of its high byte is 1.
- R9: A translating access gives `phys_addr` = {high[1:0], low[7:0], cpu_addr[13:0]}.
- R10: `map_oob` is 1 exactly when a translating access has frame number {high[1:0], low} at or above `mem_pages`.
- R11: When no window translates, `phys_addr` equals `cpu_addr` zero-extended, and `map_hit` and `map_oob` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_map_en | input | 1 | Global translation enable |
| ctl_io_en | input | 1 | I/O window decode enable |
| ctl_io_sel | input | 1 | I/O base select (1 selects 0x218, 0 selects 0x208) |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0xFF when not decoded |
| cpu_addr | input | 20 | CPU memory address |
| mem_pages | input | 11 | Installed memory size in 16 KB frames |
| phys_addr | output | 24 | Translated or passed-through address |
| map_hit | output | 1 | Address translated by an enabled window |
| map_oob | output | 1 | Translated address lies beyond installed memory |

## Verification
A behavioural model in the bench predicts the read data and the translation outputs. Both are compared on every clock.

Translation is tried under several conditions:
- A sweep of all 64 16 KB blocks below 1 MB, with every page holding a distinct frame. This separates the two window regions and the blocks just outside them.
- Page-enable and global-enable toggles. These separate R8 from the region decode.
- Three memory sizes, including one where frames straddle the limit, to probe the range check.

Register access is tried under several conditions:
- Both I/O bases, with the decode disabled and re-enabled.
- Auto-increment across the wrap from 31 to 0.
- Writes to the inactive base, each followed by readback through the active one.

// File: rtl/ems_map_pkg.sv
package ems_map_pkg;

    typedef enum logic [1:0] {
        WIN_IDLE   = 2'd0,
        WIN_BASE_A = 2'd1,
        WIN_BASE_B = 2'd2
    } win_state_t;

    typedef enum logic [1:0] {
        PORT_LO   = 2'd0,
        PORT_HI   = 2'd1,
        PORT_PTR  = 2'd2,
        PORT_NONE = 2'd3
    } port_t;

    localparam logic [7:0] LO_RESET  = 8'hFF;
    localparam logic [7:0] HI_RESET  = 8'h03;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;

endpackage

// File: rtl/ems_win_fsm.sv
module ems_win_fsm
    import ems_map_pkg::*;
#(
    parameter int          AW        = 16,
    parameter logic [15:0] IO_BASE_A = 16'h0208,
    parameter logic [15:0] IO_BASE_B = 16'h0218
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_en,
    input  logic          io_sel,
    input  logic [AW-1:0] io_addr,
    output port_t         port_sel
);
    localparam logic [AW-1:0] N_PORTS = AW'(3);
    localparam logic [AW-1:0] BASE_A  = AW'(IO_BASE_A);
    localparam logic [AW-1:0] BASE_B  = AW'(IO_BASE_B);

    win_state_t      state_q, state_d;
    logic [AW-1:0]   base_v;
    logic [AW-1:0]   offset;
    logic            active;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_IDLE;
        else        state_q <= state_d;
    end

    // transitions: enable-to-A/B, swap, disable-to-idle, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_IDLE: begin
                if (io_en) state_d = io_sel ? WIN_BASE_B : WIN_BASE_A;
            end
            WIN_BASE_A: begin
                if (!io_en)     state_d = WIN_IDLE;
                else if (io_sel) state_d = WIN_BASE_B;
            end
            WIN_BASE_B: begin
                if (!io_en)      state_d = WIN_IDLE;
                else if (!io_sel) state_d = WIN_BASE_A;
            end
            default: state_d = WIN_IDLE;
        endcase
    end

    // outputs from the current state
    always_comb begin
        base_v = BASE_A;
        active = 1'b0;
        unique case (state_q)
            WIN_IDLE:   begin base_v = BASE_A; active = 1'b0; end
            WIN_BASE_A: begin base_v = BASE_A; active = 1'b1; end
            WIN_BASE_B: begin base_v = BASE_B; active = 1'b1; end
            default:    begin base_v = BASE_A; active = 1'b0; end
        endcase
        offset   = io_addr - base_v;
        port_sel = PORT_NONE;
        if (active && (offset < N_PORTS)) port_sel = port_t'(offset[1:0]);
    end

    // R1: a disabled window leaves the machine idle on the next cycle
    p_disable_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !io_en |=> (state_q == WIN_IDLE));

    // R1: base follows the select input one cycle later
    p_base_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_en && io_sel) |=> (state_q == WIN_BASE_B));

endmodule

// File: rtl/ems_page_file.sv
module ems_page_file
    import ems_map_pkg::*;
#(
    parameter int N_WIN  = 32,
    parameter int BANK_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_ptr,
    input  logic [7:0]        wdata,
    output logic [7:0]        ptr,
    output logic [7:0]        sel_lo,
    output logic [7:0]        sel_hi,
    output logic              pg_en    [N_WIN],
    output logic [BANK_W-1:0] pg_frame [N_WIN]
);
    localparam int IDX_W = $clog2(N_WIN);
    localparam int HI_FW = BANK_W - 8;

    logic [7:0]       lo_q [N_WIN];
    logic [7:0]       hi_q [N_WIN];
    logic [7:0]       ptr_q;
    logic [IDX_W-1:0] idx;

    assign idx = ptr_q[IDX_W-1:0];

    for (genvar i = 0; i < N_WIN; i++) begin : g_page
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[i] <= LO_RESET;
                hi_q[i] <= HI_RESET;
            end else begin
                if (wr_lo && (idx == IDX_W'(i))) lo_q[i] <= wdata;
                if (wr_hi && (idx == IDX_W'(i))) hi_q[i] <= wdata;
            end
        end
        assign pg_en[i]    = hi_q[i][7];
        assign pg_frame[i] = {hi_q[i][HI_FW-1:0], lo_q[i]};
    end

    // pointer: direct load, or step after a high-byte write in auto mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ptr_q <= 8'h00;
        else if (wr_ptr)             ptr_q <= wdata;
        else if (wr_hi && ptr_q[7])  ptr_q <= {ptr_q[7:IDX_W], idx + 1'b1};
    end

    assign ptr    = ptr_q;
    assign sel_lo = lo_q[idx];
    assign sel_hi = hi_q[idx];

    // R4: auto-increment wraps in the index field and keeps the top bits
    p_autoinc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_ptr && ptr_q[7]) |=>
        ((ptr_q[IDX_W-1:0] == ($past(ptr_q[IDX_W-1:0]) + 1'b1)) &&
         (ptr_q[7:IDX_W] == $past(ptr_q[7:IDX_W]))));

    // R3: pointer only moves on a pointer write or an auto-step
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ptr && !(wr_hi && ptr_q[7])) |=> $stable(ptr_q));

endmodule

// File: rtl/ems_xlate.sv
module ems_xlate #(
    parameter int N_WIN      = 32,
    parameter int BANK_W     = 10,
    parameter int PAGE_SHIFT = 14,
    parameter int CPU_AW     = 20,
    parameter int LO_FIRST   = 16,
    parameter int LO_COUNT   = 24,
    parameter int HI_FIRST   = 52
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CPU_AW-1:0]        cpu_addr,
    input  logic                     map_en,
    input  logic                     pg_en    [N_WIN],
    input  logic [BANK_W-1:0]        pg_frame [N_WIN],
    input  logic [BANK_W:0]          mem_pages,
    output logic [BANK_W+PAGE_SHIFT-1:0] phys_addr,
    output logic                     hit,
    output logic                     oob
);
    localparam int PA_W  = BANK_W + PAGE_SHIFT;
    localparam int BLK_W = CPU_AW - PAGE_SHIFT;
    localparam int IDX_W = $clog2(N_WIN);
    localparam logic [BLK_W-1:0] LO_START = BLK_W'(LO_FIRST);
    localparam logic [BLK_W-1:0] LO_END   = BLK_W'(LO_FIRST + LO_COUNT);
    localparam logic [BLK_W-1:0] HI_START = BLK_W'(HI_FIRST);
    localparam logic [BLK_W-1:0] HI_END   = BLK_W'(HI_FIRST + N_WIN - LO_COUNT);
    localparam logic [BLK_W-1:0] HI_SHIFT = BLK_W'(HI_FIRST - LO_COUNT);

    logic [BLK_W-1:0]  blk;
    logic [BLK_W-1:0]  idx_full;
    logic [IDX_W-1:0]  idx;
    logic              in_lo, in_hi;
    logic [BANK_W-1:0] frame;

    always_comb begin
        blk      = cpu_addr[CPU_AW-1:PAGE_SHIFT];
        in_lo    = (blk >= LO_START) && (blk < LO_END);
        in_hi    = (blk >= HI_START) && (blk < HI_END);
        idx_full = in_lo ? (blk - LO_START) : (blk - HI_SHIFT);
        idx      = idx_full[IDX_W-1:0];
        frame    = pg_frame[idx];
        hit      = (in_lo || in_hi) && map_en && pg_en[idx];
        if (hit) phys_addr = {frame, cpu_addr[PAGE_SHIFT-1:0]};
        else     phys_addr = PA_W'(cpu_addr);
        oob      = hit && ({1'b0, frame} >= mem_pages);
    end

    // R11: without a hit the address passes through
    p_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (phys_addr == PA_W'(cpu_addr)) && !oob);

    // R8: no translation while the global enable is low
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !map_en |-> !hit);

    // R9: page offset is never altered
    p_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (phys_addr[PAGE_SHIFT-1:0] == cpu_addr[PAGE_SHIFT-1:0]));

endmodule

// File: rtl/ems_page_mapper.sv
module ems_page_mapper
    import ems_map_pkg::*;
#(
    parameter int          N_WIN      = 32,
    parameter int          BANK_W     = 10,
    parameter int          PAGE_SHIFT = 14,
    parameter int          CPU_AW     = 20,
    parameter int          IO_AW      = 16,
    parameter logic [15:0] IO_BASE_A  = 16'h0208,
    parameter logic [15:0] IO_BASE_B  = 16'h0218,
    parameter int          LO_FIRST   = 16,
    parameter int          LO_COUNT   = 24,
    parameter int          HI_FIRST   = 52
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ctl_map_en,
    input  logic                         ctl_io_en,
    input  logic                         ctl_io_sel,
    input  logic [IO_AW-1:0]             io_addr,
    input  logic                         io_wr,
    input  logic                         io_rd,
    input  logic [7:0]                   io_wdata,
    output logic [7:0]                   io_rdata,
    input  logic [CPU_AW-1:0]            cpu_addr,
    input  logic [BANK_W:0]              mem_pages,
    output logic [BANK_W+PAGE_SHIFT-1:0] phys_addr,
    output logic                         map_hit,
    output logic                         map_oob
);
    port_t             port_sel;
    logic              wr_lo, wr_hi, wr_ptr;
    logic [7:0]        ptr, sel_lo, sel_hi;
    logic              pg_en    [N_WIN];
    logic [BANK_W-1:0] pg_frame [N_WIN];

    ems_win_fsm #(
        .AW(IO_AW), .IO_BASE_A(IO_BASE_A), .IO_BASE_B(IO_BASE_B)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .io_en(ctl_io_en), .io_sel(ctl_io_sel),
        .io_addr(io_addr), .port_sel(port_sel)
    );

    assign wr_lo  = io_wr && (port_sel == PORT_LO);
    assign wr_hi  = io_wr && (port_sel == PORT_HI);
    assign wr_ptr = io_wr && (port_sel == PORT_PTR);

    ems_page_file #(.N_WIN(N_WIN), .BANK_W(BANK_W)) u_pages (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ptr(wr_ptr),
        .wdata(io_wdata), .ptr(ptr), .sel_lo(sel_lo), .sel_hi(sel_hi),
        .pg_en(pg_en), .pg_frame(pg_frame)
    );

    always_comb begin
        io_rdata = IDLE_BYTE;
        if (io_rd) begin
            unique case (port_sel)
                PORT_LO:   io_rdata = sel_lo;
                PORT_HI:   io_rdata = sel_hi;
                PORT_PTR:  io_rdata = ptr;
                PORT_NONE: io_rdata = IDLE_BYTE;
                default:   io_rdata = IDLE_BYTE;
            endcase
        end
    end

    ems_xlate #(
        .N_WIN(N_WIN), .BANK_W(BANK_W), .PAGE_SHIFT(PAGE_SHIFT), .CPU_AW(CPU_AW),
        .LO_FIRST(LO_FIRST), .LO_COUNT(LO_COUNT), .HI_FIRST(HI_FIRST)
    ) u_xlate (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .map_en(ctl_map_en),
        .pg_en(pg_en), .pg_frame(pg_frame), .mem_pages(mem_pages),
        .phys_addr(phys_addr), .hit(map_hit), .oob(map_oob)
    );

    // R2: a pointer written last cycle reads back unchanged
    p_ptr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_ptr) && io_rd && (port_sel == PORT_PTR) &&
         $past(port_sel == PORT_PTR)) |-> (io_rdata == $past(io_wdata)));

    // R10: out-of-range only on a translated access
    p_oob_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        map_oob |-> map_hit);

endmodule

// File: tb/test_ems_page_mapper.sv
`timescale 1ns/1ps
module test_ems_page_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_map_en = 0, ctl_io_en = 0, ctl_io_sel = 0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 0, io_rd = 0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic [19:0] cpu_addr = 20'h0;
    logic [10:0] mem_pages = 11'd1024;
    logic [23:0] phys_addr;
    logic        map_hit, map_oob;

    ems_page_mapper i_ems_page_mapper (
        .clk(clk), .rst_n(rst_n), .ctl_map_en(ctl_map_en), .ctl_io_en(ctl_io_en),
        .ctl_io_sel(ctl_io_sel), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_addr(cpu_addr),
        .mem_pages(mem_pages), .phys_addr(phys_addr), .map_hit(map_hit),
        .map_oob(map_oob)
    );

    always #2.5 clk = ~clk;

    int    n_checks = 0, n_fail = 0;
    string cur_req = "R5";
    bit    finished = 0;

    // behavioural reference
    int m_lo[32], m_hi[32];
    int m_ptr, m_dec;

    function automatic int port_of(int dec, int a);
        int base;
        if (dec == 0) return 3;
        base = (dec == 2) ? 'h218 : 'h208;
        if (a >= base && a < base + 3) return a - base;
        return 3;
    endfunction

    task automatic model_edge();
        int p;
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin m_lo[i] = 'hFF; m_hi[i] = 'h03; end
            m_ptr = 0; m_dec = 0;
            return;
        end
        p = port_of(m_dec, int'(io_addr));
        if (io_wr) begin
            if (p == 0) m_lo[m_ptr % 32] = int'(io_wdata);
            else if (p == 1) begin
                m_hi[m_ptr % 32] = int'(io_wdata);
                if (m_ptr >= 128) m_ptr = (m_ptr & 'hE0) | ((m_ptr + 1) & 'h1F);
            end else if (p == 2) m_ptr = int'(io_wdata);
        end
        m_dec = ctl_io_en ? (ctl_io_sel ? 2 : 1) : 0;
    endtask

    task automatic check(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        int p, e_rd, blk, idx, e_phys, e_hit, e_oob, fr;
        p = port_of(m_dec, int'(io_addr));
        e_rd = 'hFF;
        if (io_rd) begin
            if (p == 0) e_rd = m_lo[m_ptr % 32];
            else if (p == 1) e_rd = m_hi[m_ptr % 32];
            else if (p == 2) e_rd = m_ptr;
        end
        blk = int'(cpu_addr) >> 14;
        idx = -1;
        if (blk >= 16 && blk < 40) idx = blk - 16;
        else if (blk >= 52 && blk < 60) idx = blk - 28;
        e_phys = int'(cpu_addr); e_hit = 0; e_oob = 0;
        if (idx >= 0 && ctl_map_en && m_hi[idx] >= 128) begin
            fr = ((m_hi[idx] & 3) << 8) | m_lo[idx];
            e_phys = (fr << 14) | (int'(cpu_addr) & 'h3FFF);
            e_hit = 1;
            e_oob = (fr >= int'(mem_pages)) ? 1 : 0;
        end
        check("io_rdata", int'(io_rdata), e_rd);
        check("phys_addr", int'(phys_addr), e_phys);
        check("map_hit", int'(map_hit), e_hit);
        check("map_oob", int'(map_oob), e_oob);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic io_write(int a, int d);
        io_addr = 16'(a); io_wdata = 8'(d); io_wr = 1; io_rd = 0;
        step();
        io_wr = 0;
    endtask

    task automatic io_read(int a);
        io_addr = 16'(a); io_rd = 1;
        step();
        io_rd = 0;
    endtask

    task automatic set_ctl(bit map_en, bit en, bit sel);
        ctl_map_en = map_en; ctl_io_en = en; ctl_io_sel = sel;
        step();
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R5: reset
        cur_req = "R5";
        repeat (3) step();
        rst_n = 1;
        step();
        set_ctl(0, 1, 0);
        for (int i = 0; i < 32; i += 7) begin
            io_write('h20A, i); io_read('h208); io_read('h209);
        end
        io_write('h20A, 0);

        // R6: undecoded accesses have no effect
        cur_req = "R6";
        set_ctl(0, 0, 0);
        io_read('h208); io_read('h20A);
        io_write('h208, 'h11); io_write('h20A, 'h05);
        set_ctl(0, 1, 0);
        io_read('h208); io_read('h20A);
        io_write('h21A, 'h07);
        io_read('h20A); io_read('h20B); io_read('h207);

        // R1: base select and decode enable
        cur_req = "R1";
        io_write('h20A, 'h05);
        io_read('h21A); io_read('h20A);
        set_ctl(0, 1, 1);
        io_read('h21A); io_read('h20A);
        ctl_io_sel = 0; io_addr = 16'h21A; io_rd = 1;
        step(); step(); io_rd = 0;

        // R2 / R3: register access through pointer
        cur_req = "R2";
        set_ctl(0, 1, 1);
        for (int i = 0; i < 32; i++) begin
            io_write('h21A, i);
            io_write('h218, (i * 37 + 5) & 'hFF);
            io_write('h219, (i & 1) ? ('h80 | (i & 3)) : (i & 3));
        end
        cur_req = "R3";
        for (int i = 31; i >= 0; i -= 5) begin
            io_write('h21A, 'h60 | i); io_read('h218); io_read('h219); io_read('h21A);
        end

        // R4: auto-increment with wrap
        cur_req = "R4";
        io_write('h21A, 'hBE);
        io_write('h219, 'h81); io_read('h21A);
        io_write('h219, 'h82); io_read('h21A);
        io_write('h219, 'h83); io_read('h21A);
        io_write('h218, 'h44); io_read('h21A);
        io_write('h21A, 'h9E); io_read('h219);

        // R9 / R7: program distinct frames, sweep all blocks
        cur_req = "R9";
        io_write('h21A, 'h80);
        for (int i = 0; i < 32; i++) begin
            io_write('h21A, 'h80 | i);
            io_write('h218, (i * 29 + 3) & 'hFF);
            io_write('h219, 'h80 | (i & 3));
        end
        set_ctl(1, 1, 1);
        cur_req = "R7";
        for (int b = 0; b < 64; b++) begin
            cpu_addr = 20'((b << 14) | ((b * 1237) & 'h3FFF));
            step();
        end

        // R8: page enable and global enable
        cur_req = "R8";
        cpu_addr = 20'h40123;
        step();
        io_write('h21A, 0); io_write('h219, 'h01);
        step();
        ctl_map_en = 0; step();
        ctl_map_en = 1; io_write('h219, 'h81); step();

        // R10: installed-memory limit
        cur_req = "R10";
        foreach (m_lo[k]) begin end
        mem_pages = 11'h100;
        for (int b = 16; b < 60; b += 3) begin
            cpu_addr = 20'((b << 14) | 'h2A5); step();
        end
        mem_pages = 11'h080;
        for (int b = 16; b < 60; b += 2) begin
            cpu_addr = 20'((b << 14) | 'h3FF0); step();
        end
        io_write('h21A, 0); io_write('h218, 'h00); io_write('h219, 'h81);
        cpu_addr = 20'h40000; mem_pages = 11'h101; step();
        mem_pages = 11'h100; step();

        // R11: pass-through when not translating
        cur_req = "R11";
        io_write('h219, 'h03);
        cpu_addr = 20'h40ABC; step();
        cpu_addr = 20'hFFFFF; step();
        cpu_addr = 20'hA0000; step();
        ctl_map_en = 0; cpu_addr = 20'hD4000; step();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule